// File: doc/BRIEF.md
# Segment register load protection checker

This block decides whether a request to load a segment register, or to access memory through one, must raise a protection fault. The descriptor for the selector has already been fetched and decoded upstream. The requester presents one request per valid strobe with the following inputs:

- the target register;
- the selector;
- the decoded descriptor class and its access bits;
- the current privilege level;
- the operating mode.

One cycle later the block returns a fault flag, a 16-bit error code and a one-cycle done strobe.

Each target register has its own acceptance rules for the descriptor kind. A null selector is one whose index and table-indicator bits are all zero. How a null selector is treated depends on the register, the mode and the privilege level. A fault raised during a descriptor load reports the selector in the error code. A fault raised by a memory access through a null register reports zero.

Top module: `seg_load_guard`

## Requirements
- R1: A request is taken when `req_valid_i` is high at a rising clock edge. `done_o` is high in the next cycle and low in any cycle that follows a clock edge without a request. `fault_o` and `err_code_o` show the result in that same cycle.
- R2: `fault_o` and `err_code_o` keep their value through every cycle that follows an edge without a request.
- R3: For a load (`req_kind_i`=0) into CS (`req_seg_i`=1), the block faults when the selector is null or when the descriptor class is data (`desc_class_i`=2) or system (0). A code descriptor (1) is accepted.
- R4: For a load of a non-null selector into SS (`req_seg_i`=2), the block accepts only a data descriptor with `desc_write_i`=1. A read-only data descriptor, a code descriptor or a system descriptor faults.
- R5: For a load of a non-null selector into ES, DS, FS or GS (`req_seg_i` = 0, 3, 4, 5), the block faults on a system descriptor and on a code descriptor with `desc_read_i`=0. It accepts a readable code descriptor and any data descriptor.
- R6: Loading a null selector into ES, DS, FS or GS never faults, in any mode.
- R7: Loading a null selector into SS always faults in legacy mode (`mode_i`=0) and in compatibility mode (`mode_i`=1).
- R8: In 64-bit mode (`mode_i`=2), loading a null selector into SS faults when `cpl_i`=3. At `cpl_i` 0 to 2 it faults only when the selector's RPL (bits 1:0) differs from `cpl_i`.
- R9: A memory access (`req_kind_i`=1) faults with error code 0 exactly when the register is ES, DS, FS or GS and the selector it holds is null. An access through CS or SS never faults.
- R10: A load fault reports the selector with bits 1:0 cleared. Bits 15:3 hold the index and bit 2 holds the table indicator. A result without a fault reports an error code of 0.
- R11: While reset is held, and after it is released until the first request, `fault_o`, `done_o` and `err_code_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 1 | 0 = register load, 1 = memory access through the register |
| req_seg_i | input | 3 | Target register: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| req_sel_i | input | 16 | Selector being loaded, or the selector held by the register |
| desc_class_i | input | 2 | Descriptor class: 0 system, 1 code, 2 data |
| desc_read_i | input | 1 | Code descriptor is readable |
| desc_write_i | input | 1 | Data descriptor is writable |
| cpl_i | input | 2 | Current privilege level |
| mode_i | input | 2 | 0 legacy, 1 compatibility, 2 64-bit |
| fault_o | output | 1 | Protection fault for the last request |
| err_code_o | output | 16 | Error code for the last request |
| done_o | output | 1 | Result valid, one cycle per request |

## Verification
The assertions assume that every request input is stable and known at the edge where `req_valid_i` is sampled. They also assume that `req_seg_i` stays within the six defined encodings and that `mode_i` never takes the value 3. The bench drives all inputs on the falling edge and uses only defined encodings for the target register and the mode. It sets descriptor fields to the values a real descriptor fetch could produce for each case.

// File: rtl/seg_guard_pkg.sv
package seg_guard_pkg;
  localparam int unsigned SEL_W  = 16;
  localparam int unsigned RPL_W  = 2;

  localparam logic [2:0] SEG_ES = 3'd0;
  localparam logic [2:0] SEG_CS = 3'd1;
  localparam logic [2:0] SEG_SS = 3'd2;
  localparam logic [2:0] SEG_DS = 3'd3;
  localparam logic [2:0] SEG_FS = 3'd4;
  localparam logic [2:0] SEG_GS = 3'd5;

  localparam logic [1:0] CLS_SYS  = 2'd0;
  localparam logic [1:0] CLS_CODE = 2'd1;
  localparam logic [1:0] CLS_DATA = 2'd2;

  localparam logic [1:0] MODE_LEGACY = 2'd0;
  localparam logic [1:0] MODE_COMPAT = 2'd1;
  localparam logic [1:0] MODE_LONG   = 2'd2;

  localparam logic KIND_LOAD = 1'b0;
  localparam logic KIND_MEM  = 1'b1;

  typedef struct packed {
    logic fault;
    logic load_src;
  } verdict_t;

  function automatic logic sel_is_null(input logic [SEL_W-1:0] sel);
    return sel[SEL_W-1:RPL_W] == '0;
  endfunction
endpackage

// File: rtl/sg_rule_eval.sv
module sg_rule_eval
  import seg_guard_pkg::*;
(
  input  logic             kind_i,
  input  logic [2:0]       seg_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       cls_i,
  input  logic             rd_i,
  input  logic             wr_i,
  input  logic [1:0]       cpl_i,
  input  logic [1:0]       mode_i,
  output verdict_t         verdict_o
);
  logic nul, is_cs, is_ss, is_data_reg;
  logic cs_bad, ss_bad, dreg_bad, ss_null_bad, mem_bad;

  assign nul         = sel_is_null(sel_i);
  assign is_cs       = seg_i == SEG_CS;
  assign is_ss       = seg_i == SEG_SS;
  assign is_data_reg = !is_cs && !is_ss;

  always_comb begin
    unique case (mode_i)
      MODE_LONG:   ss_null_bad = (cpl_i == 2'd3) || (sel_i[RPL_W-1:0] != cpl_i);
      default:     ss_null_bad = 1'b1;
    endcase
  end

  assign cs_bad   = nul || (cls_i != CLS_CODE);
  assign ss_bad   = nul ? ss_null_bad : !((cls_i == CLS_DATA) && wr_i);
  assign dreg_bad = !nul && ((cls_i == CLS_SYS) || ((cls_i == CLS_CODE) && !rd_i));
  assign mem_bad  = is_data_reg && nul;

  always_comb begin
    verdict_o.load_src = (kind_i == KIND_LOAD);
    if (kind_i == KIND_MEM)  verdict_o.fault = mem_bad;
    else if (is_cs)          verdict_o.fault = cs_bad;
    else if (is_ss)          verdict_o.fault = ss_bad;
    else                     verdict_o.fault = dreg_bad;
  end
endmodule

// File: rtl/sg_errcode_gen.sv
module sg_errcode_gen
  import seg_guard_pkg::*;
(
  input  verdict_t         verdict_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] err_o
);
  // bits 1:0 stay zero: not a vector-table reference, not external
  always_comb begin
    err_o = '0;
    if (verdict_i.fault && verdict_i.load_src)
      err_o = {sel_i[SEL_W-1:RPL_W], {RPL_W{1'b0}}};
  end
endmodule

// File: rtl/sg_result_reg.sv
module sg_result_reg
  import seg_guard_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             fault_i,
  input  logic [SEL_W-1:0] err_i,
  output logic             fault_o,
  output logic [SEL_W-1:0] err_o,
  output logic             done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_o <= 1'b0;
      err_o   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        fault_o <= fault_i;
        err_o   <= err_i;
      end
    end
  end
endmodule

// File: rtl/seg_load_guard.sv
module seg_load_guard
  import seg_guard_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        req_kind_i,
  input  logic [2:0]  req_seg_i,
  input  logic [15:0] req_sel_i,
  input  logic [1:0]  desc_class_i,
  input  logic        desc_read_i,
  input  logic        desc_write_i,
  input  logic [1:0]  cpl_i,
  input  logic [1:0]  mode_i,
  output logic        fault_o,
  output logic [15:0] err_code_o,
  output logic        done_o
);
  verdict_t         verdict;
  logic [SEL_W-1:0] err_d;

  sg_rule_eval u_rules (
    .kind_i   (req_kind_i),
    .seg_i    (req_seg_i),
    .sel_i    (req_sel_i),
    .cls_i    (desc_class_i),
    .rd_i     (desc_read_i),
    .wr_i     (desc_write_i),
    .cpl_i    (cpl_i),
    .mode_i   (mode_i),
    .verdict_o(verdict)
  );

  sg_errcode_gen u_err (
    .verdict_i(verdict),
    .sel_i    (req_sel_i),
    .err_o    (err_d)
  );

  sg_result_reg u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(req_valid_i),
    .fault_i(verdict.fault),
    .err_i  (err_d),
    .fault_o(fault_o),
    .err_o  (err_code_o),
    .done_o (done_o)
  );
endmodule

// File: rtl/sg_guard_chk.sv
module sg_guard_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_kind_i,
  input logic [2:0]  req_seg_i,
  input logic [15:0] req_sel_i,
  input logic [1:0]  desc_class_i,
  input logic        desc_read_i,
  input logic        desc_write_i,
  input logic [1:0]  cpl_i,
  input logic [1:0]  mode_i,
  input logic        fault_o,
  input logic [15:0] err_code_o,
  input logic        done_o
);
  logic nul, dreg, load;
  assign nul  = req_sel_i[15:2] == 14'd0;
  assign dreg = (req_seg_i != 3'd1) && (req_seg_i != 3'd2);
  assign load = !req_kind_i;

  p_done_on_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> done_o);
  p_done_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !done_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> ($stable(fault_o) && $stable(err_code_o)));
  p_cs_null_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && load && req_seg_i == 3'd1 && nul) |=> fault_o);
  p_ss_ok_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && load && req_seg_i == 3'd2 && !nul && desc_class_i == 2'd2 && desc_write_i)
      |=> !fault_o);
  p_dreg_null_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && load && dreg && nul) |=> !fault_o);
  p_ss_null_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && load && req_seg_i == 3'd2 && nul && mode_i != 2'd2) |=> fault_o);
  p_mem_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i) |=> (fault_o == $past(dreg && nul)) && err_code_o == 16'd0);
  p_err_fmt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && load) |=> (err_code_o == (fault_o ? ($past(req_sel_i) & 16'hFFFC) : 16'd0)));
  p_idle_reset_r11: assert property (@(posedge clk_i)
    !rst_ni |-> (!done_o && !fault_o && err_code_o == 16'd0));
endmodule

bind seg_load_guard sg_guard_chk u_chk (.*);

// File: tb/seg_load_guard_tb.sv
module seg_load_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, kind = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0]  seg = '0;
  logic [15:0] sel = '0;
  logic [1:0]  cls = '0, cpl = '0, mode = '0;
  logic        fault, done;
  logic [15:0] err;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  seg_load_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_kind_i(kind),
    .req_seg_i(seg), .req_sel_i(sel), .desc_class_i(cls), .desc_read_i(rd),
    .desc_write_i(wr), .cpl_i(cpl), .mode_i(mode),
    .fault_o(fault), .err_code_o(err), .done_o(done)
  );

  typedef struct packed {
    logic        kind;
    logic [2:0]  seg;
    logic [15:0] sel;
    logic [1:0]  cls;
    logic        rd;
    logic        wr;
    logic [1:0]  cpl;
    logic [1:0]  mode;
    logic        xf;
    logic [15:0] xe;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{0,1,16'h0028,2,0,1,0,0, 1,16'h0028, 3},  // R3 data into CS
    '{0,1,16'h002B,1,1,0,3,0, 0,16'h0000, 3},  // R3 code into CS
    '{0,1,16'h0003,1,1,0,3,0, 1,16'h0000, 3},  // R3 null CS
    '{0,1,16'h0030,0,0,0,0,2, 1,16'h0030, 3},  // R3 system into CS
    '{0,2,16'h0010,2,1,1,0,0, 0,16'h0000, 4},  // R4 writable data
    '{0,2,16'h0018,2,1,0,0,0, 1,16'h0018, 4},  // R4 read-only data
    '{0,2,16'h003F,1,1,0,3,1, 1,16'h003C, 10}, // R10 SS code, RPL cleared
    '{0,2,16'h0044,0,0,0,0,0, 1,16'h0044, 4},  // R4 SS system, TI set
    '{0,3,16'h0050,0,0,0,0,0, 1,16'h0050, 5},  // R5 DS system
    '{0,0,16'h005E,1,0,0,2,0, 1,16'h005C, 5},  // R5 ES execute-only
    '{0,4,16'h0060,1,1,0,0,1, 0,16'h0000, 5},  // R5 FS readable code
    '{0,5,16'h0068,2,1,0,0,2, 0,16'h0000, 5},  // R5 GS read-only data
    '{0,3,16'h0000,0,0,0,0,0, 0,16'h0000, 6},  // R6 DS null legacy
    '{0,5,16'h0003,0,0,0,3,2, 0,16'h0000, 6},  // R6 GS null 64-bit
    '{0,2,16'h0000,2,1,1,0,0, 1,16'h0000, 7},  // R7 SS null legacy
    '{0,2,16'h0001,2,1,1,1,1, 1,16'h0000, 7},  // R7 SS null compat, RPL==CPL
    '{0,2,16'h0003,2,1,1,3,2, 1,16'h0000, 8},  // R8 64-bit CPL3
    '{0,2,16'h0001,2,1,1,1,2, 0,16'h0000, 8},  // R8 64-bit RPL==CPL
    '{0,2,16'h0000,2,1,1,2,2, 1,16'h0000, 8},  // R8 64-bit RPL!=CPL
    '{1,3,16'h0000,2,1,1,0,0, 1,16'h0000, 9},  // R9 DS null access
    '{1,4,16'h0002,2,1,1,2,1, 1,16'h0000, 9},  // R9 FS null, RPL 2
    '{1,0,16'h0028,2,1,1,0,0, 0,16'h0000, 9},  // R9 ES non-null
    '{1,2,16'h0000,2,1,1,0,0, 0,16'h0000, 9},  // R9 SS not checked
    '{1,5,16'h0004,2,1,1,0,2, 0,16'h0000, 9}   // R9 TI set is not null
  };

  task automatic chk(input string rq, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    valid = 1'b1; kind = v.kind; seg = v.seg; sel = v.sel; cls = v.cls;
    rd = v.rd; wr = v.wr; cpl = v.cpl; mode = v.mode;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] hold_e;
    logic        hold_f;
    repeat (3) @(negedge clk);
    chk("R11 in reset", {done, fault, err[14:0]}, 17'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after reset", {done, fault, err[14:0]}, 17'd0);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      @(negedge clk);
      valid = 1'b0;
      chk($sformatf("R%0d vec%0d done R1", VECS[i].rq, i), {16'd0, done}, 17'd1);
      chk($sformatf("R%0d vec%0d", VECS[i].rq, i), {fault, err}, {VECS[i].xf, VECS[i].xe});
      hold_f = fault; hold_e = err;
      sel = 16'hFFFF; seg = 3'd1; kind = 1'b0; cls = 2'd2;
      @(negedge clk);
      chk("R1 done drops", {16'd0, done}, 17'd0);
      chk("R2 hold", {fault, err}, {hold_f, hold_e});
    end

    // back-to-back requests: done stays high, second result wins
    issue(VECS[0]);
    issue(VECS[1]);
    @(negedge clk);
    valid = 1'b0;
    chk("R1 back-to-back done", {16'd0, done}, 17'd1);
    chk("R3 back-to-back result", {fault, err}, 17'd0);

    // fault then reset mid-run clears outputs
    issue(VECS[0]);
    @(negedge clk);
    valid = 1'b0;
    chk("R10 before reset", {fault, err}, {1'b1, 16'h0028});
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset clears", {done, fault, err[14:0]}, 17'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {done, fault, err[14:0]}, 17'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule